// File: doc/BRIEF.md
# Store-Protection Latch and Store Sequencer

This block guards a small shadow RAM and its nonvolatile backing array. It holds two protection flags. The write-enable flag permits RAM writes and stores. The recall-armed flag records that a recall was requested after power-up. The block also times the store cycle that copies RAM into the nonvolatile array. An upstream serial decoder feeds it one-cycle command strobes. A separate active-low recall pin can request a recall from outside.

The array is not modelled here. A store is a fixed number of clock cycles counted by a timer, and the busy flag covers that span. A store is launched only when both flags are set. While a store runs, every other command is dropped. When the store ends, the write-enable flag clears itself. The recall-armed flag cannot be set by the automatic recall that follows power-up, so software must recall on purpose before any store can run.

Top module: `store_guard`

## Requirements
- R1: After reset both flags are clear and `busy`, `store_req` and `recall_req` are 0. Exactly one `recall_req` pulse follows reset release. That pulse leaves the recall-armed flag clear, so `cmd_set_we` followed by `cmd_store` starts no store.
- R2: Outside a store, `cmd_set_we` sets the write-enable flag and `cmd_clr_we` clears it. When both arrive in the same cycle, clearing wins.
- R3: `wr_permit` is high in the same cycle as `cmd_write` only when the write-enable flag is set and no store is running. Otherwise the write has no effect.
- R4: Outside a store, `cmd_recall` gives a one-cycle `recall_req` on the following cycle and sets the recall-armed flag.
- R5: A falling edge on `recall_pin_n` is synchronized through two stages and edge-detected. It yields exactly one `recall_req` pulse however long the pin stays low, and it sets the recall-armed flag.
- R6: `cmd_store` starts a store only when both flags are set and no store is running. A start shows as a one-cycle `store_req` with `busy` rising on the cycle after the strobe. Otherwise `cmd_store` is ignored.
- R7: `busy` stays high for exactly `STORE_CYCLES` consecutive cycles for each store.
- R8: While `busy` is high, write, recall (strobe or pin edge), store and flag commands are all ignored. No `recall_req`, `store_req` or `wr_permit` is produced.
- R9: When a store completes, the write-enable flag is cleared and the recall-armed flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset, released synchronously inside |
| cmd_set_we | input | 1 | Strobe: set write-enable flag |
| cmd_clr_we | input | 1 | Strobe: clear write-enable flag |
| cmd_store | input | 1 | Strobe: copy RAM to nonvolatile array |
| cmd_recall | input | 1 | Strobe: software recall |
| cmd_write | input | 1 | Strobe: RAM write request |
| recall_pin_n | input | 1 | Asynchronous active-low hardware recall pin |
| wr_permit | output | 1 | RAM write allowed this cycle |
| recall_req | output | 1 | One-cycle recall request to the array |
| busy | output | 1 | Store cycle in progress |
| store_req | output | 1 | One-cycle store launch to the array |

## Verification
The assertions assume that command strobes come from a decoder clocked by `clk`, so each strobe is a clean single-cycle level that is stable around the sampling edge. Only `recall_pin_n` may change at any time. The bench drives every strobe on the falling edge and holds it for exactly one cycle. It moves the recall pin only between clock edges and keeps it high during reset, so the first synchronized sample is inactive.

// File: rtl/sg_pkg.sv
package sg_pkg;
  // Bundle of decoded command strobes.
  typedef struct packed {
    logic set_we;
    logic clr_we;
    logic store;
    logic recall;
    logic write;
  } sg_cmd_t;

  localparam int SG_SYNC_STAGES = 2;
endpackage

// File: rtl/sg_rst_sync.sv
module sg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/sg_pin_edge.sv
module sg_pin_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  output logic fall
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;
  logic              prev_q;
  logic              prev_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], pin_n};
    prev_d = sync_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  assign fall = prev_q & ~sync_q[STAGES-1];
endmodule

// File: rtl/sg_arming.sv
module sg_arming
  import sg_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  sg_cmd_t cmd,
  input  logic    busy,
  input  logic    store_done,
  input  logic    recall_take,
  output logic    wel,
  output logic    prl
);
  logic wel_q, wel_d;
  logic prl_q, prl_d;

  always_comb begin
    wel_d = wel_q;
    if (busy) begin
      if (store_done) wel_d = 1'b0;
    end else if (cmd.clr_we) begin
      wel_d = 1'b0;
    end else if (cmd.set_we) begin
      wel_d = 1'b1;
    end
    prl_d = prl_q | recall_take;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel_q <= 1'b0;
      prl_q <= 1'b0;
    end else begin
      wel_q <= wel_d;
      prl_q <= prl_d;
    end
  end

  assign wel = wel_q;
  assign prl = prl_q;
endmodule

// File: rtl/sg_store_timer.sv
module sg_store_timer #(
  parameter int CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done,
  output logic store_req
);
  localparam int CW = (CYCLES < 2) ? 1 : $clog2(CYCLES);
  localparam logic [CW-1:0] LOAD = CW'(CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          busy_q, busy_d;
  logic          req_q, req_d;

  always_comb begin
    cnt_d  = cnt_q;
    busy_d = busy_q;
    req_d  = 1'b0;
    if (busy_q) begin
      if (cnt_q == '0) busy_d = 1'b0;
      else             cnt_d  = cnt_q - 1'b1;
    end else if (start) begin
      busy_d = 1'b1;
      cnt_d  = LOAD;
      req_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      req_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
      req_q  <= req_d;
    end
  end

  assign busy      = busy_q;
  assign done      = busy_q & (cnt_q == '0);
  assign store_req = req_q;
endmodule

// File: rtl/store_guard.sv
module store_guard
  import sg_pkg::*;
#(
  parameter int STORE_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_set_we,
  input  logic cmd_clr_we,
  input  logic cmd_store,
  input  logic cmd_recall,
  input  logic cmd_write,
  input  logic recall_pin_n,
  output logic wr_permit,
  output logic recall_req,
  output logic busy,
  output logic store_req
);
  logic    rst_n_int;
  sg_cmd_t cmd;
  logic    pin_fall;
  logic    wel, prl;
  logic    store_done;
  logic    recall_take;
  logic    store_start;
  logic    por_done_q, por_done_d;
  logic    rreq_q, rreq_d;

  assign cmd = '{set_we: cmd_set_we, clr_we: cmd_clr_we, store: cmd_store,
                 recall: cmd_recall, write: cmd_write};

  sg_rst_sync #(.STAGES(SG_SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_int));

  sg_pin_edge #(.STAGES(SG_SYNC_STAGES)) u_pin (
    .clk(clk), .rst_n(rst_n_int), .pin_n(recall_pin_n), .fall(pin_fall));

  assign recall_take = ~busy & (cmd.recall | pin_fall);
  assign store_start = ~busy & cmd.store & wel & prl;

  sg_arming u_arm (
    .clk(clk), .rst_n(rst_n_int), .cmd(cmd), .busy(busy),
    .store_done(store_done), .recall_take(recall_take),
    .wel(wel), .prl(prl));

  sg_store_timer #(.CYCLES(STORE_CYCLES)) u_tmr (
    .clk(clk), .rst_n(rst_n_int), .start(store_start),
    .busy(busy), .done(store_done), .store_req(store_req));

  // Power-up recall: one pulse, does not arm stores.
  always_comb begin
    por_done_d = 1'b1;
    rreq_d     = ~por_done_q | recall_take;
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      por_done_q <= 1'b0;
      rreq_q     <= 1'b0;
    end else begin
      por_done_q <= por_done_d;
      rreq_q     <= rreq_d;
    end
  end

  assign recall_req = rreq_q;
  assign wr_permit  = cmd.write & wel & ~busy;
endmodule

// File: rtl/store_guard_chk.sv
module store_guard_chk #(
  parameter int CYCLES = 8
) (
  input logic clk,
  input logic rst_n,
  input logic cmd_clr_we,
  input logic cmd_store,
  input logic cmd_recall,
  input logic cmd_write,
  input logic wr_permit,
  input logic recall_req,
  input logic busy,
  input logic store_req,
  input logic wel,
  input logic prl
);
  localparam int LW = $clog2(CYCLES + 2);
  logic [LW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_q <= '0;
    else if (busy) run_q <= run_q + 1'b1;
    else           run_q <= '0;
  end

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cmd_clr_we) && !$past(busy) |-> !wel);                         // R2
  AST_WRITE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_permit |-> cmd_write && wel && !busy);                            // R3
  AST_RECALL_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cmd_recall) && !$past(busy) |-> recall_req && prl);            // R4
  AST_STORE_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cmd_store) && $past(wel) && $past(prl) && store_req); // R6
  AST_BUSY_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> run_q == LW'(CYCLES));                               // R7
  AST_BUSY_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> run_q < LW'(CYCLES));                                       // R7
  AST_QUIET_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy) |-> !recall_req && !store_req);                          // R8
  AST_WEL_AUTOCLR: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !wel && prl);                                        // R9
endmodule

bind store_guard store_guard_chk #(.CYCLES(STORE_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n_int), .cmd_clr_we(cmd_clr_we),
  .cmd_store(cmd_store), .cmd_recall(cmd_recall), .cmd_write(cmd_write),
  .wr_permit(wr_permit), .recall_req(recall_req), .busy(busy),
  .store_req(store_req), .wel(wel), .prl(prl));

// File: tb/sim_store_guard.sv
`timescale 1ns/1ps
module sim_store_guard;
  localparam int SC = 8;
  localparam int NV = 22;
  // {req[3:0], set_we, clr_we, store, recall, write, permit, rreq, busy, sreq}
  localparam logic [12:0] VEC [NV] = '{
    {4'd3, 5'b00001, 4'b0000},  // R3 write with flag clear
    {4'd6, 5'b00100, 4'b0000},  // R6 store unarmed
    {4'd2, 5'b10000, 4'b0000},  // R2 set flag
    {4'd3, 5'b00001, 4'b1000},  // R3 write permitted
    {4'd6, 5'b00100, 4'b0000},  // R6 no recall yet
    {4'd4, 5'b00010, 4'b0100},  // R4 software recall
    {4'd2, 5'b11000, 4'b0000},  // R2 both: clear wins
    {4'd2, 5'b00001, 4'b0000},  // R2 flag now clear
    {4'd2, 5'b10000, 4'b0000},  // R2 set again
    {4'd6, 5'b00100, 4'b0011},  // R6 store starts
    {4'd7, 5'b00000, 4'b0010},  // R7
    {4'd8, 5'b00001, 4'b0010},  // R8 write blocked
    {4'd8, 5'b00010, 4'b0010},  // R8 recall blocked
    {4'd8, 5'b00100, 4'b0010},  // R8 store blocked
    {4'd8, 5'b10000, 4'b0010},  // R8 flag cmd blocked
    {4'd7, 5'b00000, 4'b0010},  // R7
    {4'd7, 5'b00000, 4'b0010},  // R7 last busy cycle
    {4'd7, 5'b00000, 4'b0000},  // R7 busy drops
    {4'd9, 5'b00001, 4'b0000},  // R9 flag cleared by store
    {4'd9, 5'b00100, 4'b0000},  // R9 store refused
    {4'd9, 5'b10000, 4'b0000},  // R9 re-enable
    {4'd9, 5'b00001, 4'b1000}   // R9 recall flag kept
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_set_we = 0, cmd_clr_we = 0, cmd_store = 0, cmd_recall = 0, cmd_write = 0;
  logic recall_pin_n = 1'b1;
  logic wr_permit, recall_req, busy, store_req;
  int checks = 0, fails = 0, rr_cnt = 0;
  bit done = 0;

  always #4 clk = ~clk;

  store_guard #(.STORE_CYCLES(SC)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_set_we(cmd_set_we), .cmd_clr_we(cmd_clr_we),
    .cmd_store(cmd_store), .cmd_recall(cmd_recall), .cmd_write(cmd_write),
    .recall_pin_n(recall_pin_n), .wr_permit(wr_permit), .recall_req(recall_req),
    .busy(busy), .store_req(store_req));

  always @(negedge clk) if (recall_req === 1'b1) rr_cnt++;

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic drive(logic [4:0] c);
    {cmd_set_we, cmd_clr_we, cmd_store, cmd_recall, cmd_write} = c;
  endtask

  task automatic cyc(logic [4:0] c);
    drive(c);
    @(posedge clk);
    @(negedge clk);
    drive(5'b0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    cmd_write = 1'b1;
    #1;
    check("R1 reset permit", int'(wr_permit), 0);
    check("R1 reset busy", int'(busy), 0);
    check("R1 reset store_req", int'(store_req), 0);
    check("R1 reset recall_req", int'(recall_req), 0);
    cmd_write = 1'b0;
    repeat (3) @(negedge clk);
    rr_cnt = 0;
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    check("R1 power-up recall pulses", rr_cnt, 1);
  endtask

  initial begin
    int blen;
    repeat (2) @(negedge clk);
    do_reset();
    // Vector walk
    for (int i = 0; i < NV; i++) begin
      logic [12:0] v;
      v = VEC[i];
      drive(v[8:4]);
      #1;
      check($sformatf("R%0d step %0d permit", v[12:9], i), int'(wr_permit), int'(v[3]));
      @(posedge clk);
      @(negedge clk);
      drive(5'b0);
      check($sformatf("R%0d step %0d recall_req", v[12:9], i), int'(recall_req), int'(v[2]));
      check($sformatf("R%0d step %0d busy", v[12:9], i), int'(busy), int'(v[1]));
      check($sformatf("R%0d step %0d store_req", v[12:9], i), int'(store_req), int'(v[0]));
    end
    // R1: reset clears recall flag, power-up recall does not arm
    do_reset();
    cyc(5'b10000);
    cyc(5'b00100);
    check("R1 store refused after reset", int'(busy), 0);
    // R5: held pin gives one pulse and arms
    rr_cnt = 0;
    recall_pin_n = 1'b0;
    repeat (10) @(negedge clk);
    check("R5 pin pulses", rr_cnt, 1);
    recall_pin_n = 1'b1;
    repeat (4) @(negedge clk);
    cyc(5'b00100);
    check("R5 pin armed store", int'(busy), 1);
    // R8 pin during store; R7 length
    rr_cnt = 0;
    recall_pin_n = 1'b0;
    blen = 0;
    for (int k = 0; k < 40 && busy; k++) begin
      blen++;
      @(negedge clk);
    end
    check("R7 busy length", blen, SC);
    repeat (6) @(negedge clk);
    check("R8 pin ignored during store", rr_cnt, 0);
    recall_pin_n = 1'b1;
    drive(5'b00001);
    #1;
    check("R9 flag cleared after store", int'(wr_permit), 0);
    drive(5'b0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule